// File: doc/BRIEF.md
# AHB Slave Wrapper Control State Machine

This block is the control core of an AHB slave port that sits in front of embedded instruction and data memories and a compute engine. It watches the slave select, the transfer type, the direction and the bus ready line. It also takes a flag that says whether the current address falls inside the memories, and a flag that marks the reserved control address. From these it decides, cycle by cycle, how the slave answers. It drives the slave ready and response lines, one-cycle memory read and write strobes, and a one-cycle start strobe for the compute engine. The memories, the address arithmetic and the engine itself live outside.

Six states shape the answer. The first is Idle. The second is an accessible state for beats that complete without wait. The third is a read-latency wait that holds ready low for `RD_LAT` cycles on the first read of a burst. The fourth is a write-pause state entered when a write burst shows BUSY. The fifth is an error state that issues the two-cycle ERROR response. The last is a working state, entered by writing the control address. While the engine runs, every access gets a two-cycle RETRY response and never reaches the memories.

Top module: `ahb_slave_ctrl_fsm`

## Requirements
- R1: After a synchronous active-low reset the slave shows ready high, response OKAY (hresp 2'b00), and all three strobes low.
- R2: Some transfers get a zero-wait OKAY response and raise no strobe: transfers with htrans IDLE (2'b00), transfers with htrans BUSY (2'b01) seen from Idle, and transfers with the select low. The next access is then handled as if they had not occurred.
- R3: A NONSEQ (2'b10) write to a valid address seen in Idle completes with zero wait. mem_we is high for exactly the following cycle, which is the write's data phase. SEQ (2'b11) writes that follow it behave the same way.
- R4: A NONSEQ read to a valid address holds ready low with OKAY for RD_LAT cycles after its address phase. In the cycle after those, ready is high and mem_re is high.
- R5: SEQ reads that continue a read burst complete with zero wait, one beat per cycle, each with mem_re high in its data phase.
- R6: A BUSY transfer inside a write burst gets a zero-wait OKAY response with no strobe. A following SEQ write resumes with zero wait and mem_we in its data phase.
- R7: A read that does not continue a read burst pays the RD_LAT wait again. This covers a read after a write beat and a NONSEQ read in the middle of traffic.
- R8: An active beat with the address-valid flag low produces ERROR (hresp 2'b01) for two cycles, with ready low in the first and high in the second, and no strobe. Idle behaviour follows. An address offered in the second error cycle is ignored.
- R9: A SEQ transfer seen in Idle is treated as an unexpected access and gets the two-cycle ERROR response.
- R10: A NONSEQ write to the control address seen in Idle completes with zero wait and raises eng_start for exactly one cycle.
- R11: While the engine runs, every NONSEQ or SEQ access gets RETRY (hresp 2'b10) for two cycles, with ready low then high. No memory strobe and no further eng_start is raised.
- R12: When eng_done is seen in the working state, the slave returns to Idle in the next cycle and handles the next access normally. If a retry is in progress, it finishes first.
- R13: An access to the control address is an error in two cases: when it is a read, and when it arrives outside Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hwrite | input | 1 | High for write, low for read |
| hready | input | 1 | Bus-level ready; the address phase is sampled only when high |
| addr_ok | input | 1 | Current address lies inside the memory depth |
| ctrl_hit | input | 1 | Current address is the reserved engine control address |
| eng_done | input | 1 | Engine finished its job |
| hreadyout | output | 1 | Slave ready |
| hresp | output | 2 | Response: 00 OKAY, 01 ERROR, 10 RETRY |
| mem_re | output | 1 | Read strobe in the completing data phase of a read beat |
| mem_we | output | 1 | Write strobe in the data phase of a write beat |
| eng_start | output | 1 | One-cycle engine start strobe |

## Verification
The bench builds the block with RD_LAT = 2, the read latency the wrapper is meant for. Its behavioural model takes the latency as a parameter of its own, so a rebuild with another value changes only one constant. The bench feeds hreadyout back as hready, as on a single-slave bus. Because of that loop, every wait, error and retry cycle really holds the master's address phase. It also lets burst streaming, BUSY pauses and the ignored address in the second error cycle all happen in the sequences the bench drives.

// File: rtl/ahbw_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the AHB slave wrapper control block.
// Assumes the standard two-bit transfer and response codings on the bus.
package ahbw_pkg;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [1:0] RSP_OKAY  = 2'b00;
    localparam logic [1:0] RSP_ERROR = 2'b01;
    localparam logic [1:0] RSP_RETRY = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ACCESS   = 3'd1,
        ST_ALU_WORK = 3'd2,
        ST_RD_WAIT  = 3'd3,
        ST_WR_WAIT  = 3'd4,
        ST_ERROR    = 3'd5
    } wrap_state_e;

endpackage

// File: rtl/ahbw_xfer_decode.sv
`timescale 1ns/1ps
// Classifies the address phase presented on the bus this cycle.
// Assumes an address phase counts only when the slave is selected
// and the bus ready is high; BUSY and IDLE never count as active.
module ahbw_xfer_decode
    import ahbw_pkg::*;
(
    input  logic       hsel,
    input  logic       hready,
    input  logic [1:0] htrans,
    output logic       xf_act,
    output logic       xf_busy,
    output logic       xf_nonseq,
    output logic       xf_seq
);

    logic sampled;

    // Qualify the transfer type with select and bus ready.
    always_comb begin
        sampled   = hsel && hready;
        xf_nonseq = sampled && (htrans == TR_NONSEQ);
        xf_seq    = sampled && (htrans == TR_SEQ);
        xf_busy   = sampled && (htrans == TR_BUSY);
        xf_act    = xf_nonseq || xf_seq;
    end

endmodule

// File: rtl/ahbw_rd_wait_cnt.sv
`timescale 1ns/1ps
// Counts the read-latency wait cycles.
// Assumes load is raised on the edge that enters the wait state and
// adv is high for every cycle spent in it; last marks the final one.
module ahbw_rd_wait_cnt #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic adv,
    output logic last
);

    localparam int CW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(RD_LAT - 1);

    logic [CW-1:0] cnt_q;

    // Restart on load, otherwise step once per wait cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (adv && (cnt_q != LAST_CNT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_CNT);

endmodule

// File: rtl/ahbw_resp_phase.sv
`timescale 1ns/1ps
// Sequences the two cycles of an ERROR or RETRY response.
// Assumes kick is a single-cycle request; a kick during the second
// cycle restarts the sequence.
module ahbw_resp_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic ph_first,
    output logic ph_second
);

    // Shift the kick through the two response cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_first  <= 1'b0;
            ph_second <= 1'b0;
        end else begin
            ph_first  <= kick;
            ph_second <= ph_first;
        end
    end

endmodule

// File: rtl/ahb_slave_ctrl_fsm.sv
`timescale 1ns/1ps
// Control state machine for an AHB slave fronting embedded memories
// and a compute engine. Decides ready and response, issues memory
// strobes and the engine start. Assumes addr_ok and ctrl_hit are
// decoded from the same address phase as htrans, and that the
// memories and address generation live outside this block.
module ahb_slave_ctrl_fsm
    import ahbw_pkg::*;
#(
    parameter int RD_LAT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsel,
    input  logic [1:0] htrans,
    input  logic       hwrite,
    input  logic       hready,
    input  logic       addr_ok,
    input  logic       ctrl_hit,
    input  logic       eng_done,
    output logic       hreadyout,
    output logic [1:0] hresp,
    output logic       mem_re,
    output logic       mem_we,
    output logic       eng_start
);

    wrap_state_e st_q, st_d;
    logic dir_w_q, dir_w_d;
    logic done_pend_q, done_pend_d;
    logic re_q, we_q, start_q;
    logic re_d, we_d, start_d;
    logic err_kick, rty_kick, wait_load, beat_bad;
    logic xf_act, xf_busy, xf_nonseq, xf_seq;
    logic wait_last, ph_first, ph_second;

    ahbw_xfer_decode u_dec (
        .hsel      (hsel),
        .hready    (hready),
        .htrans    (htrans),
        .xf_act    (xf_act),
        .xf_busy   (xf_busy),
        .xf_nonseq (xf_nonseq),
        .xf_seq    (xf_seq)
    );

    ahbw_rd_wait_cnt #(.RD_LAT(RD_LAT)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wait_load),
        .adv   (st_q == ST_RD_WAIT),
        .last  (wait_last)
    );

    ahbw_resp_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick      (err_kick || rty_kick),
        .ph_first  (ph_first),
        .ph_second (ph_second)
    );

    // Next-state and strobe decisions for the current cycle.
    always_comb begin
        st_d        = st_q;
        dir_w_d     = dir_w_q;
        done_pend_d = 1'b0;
        re_d        = 1'b0;
        we_d        = 1'b0;
        start_d     = 1'b0;
        err_kick    = 1'b0;
        rty_kick    = 1'b0;
        wait_load   = 1'b0;
        beat_bad    = !addr_ok
                   || ((st_q == ST_IDLE) && xf_seq)
                   || (ctrl_hit && !((st_q == ST_IDLE) && xf_nonseq && hwrite));
        case (st_q)
            ST_IDLE, ST_ACCESS, ST_WR_WAIT: begin
                if (xf_act) begin
                    if (beat_bad) begin
                        st_d     = ST_ERROR;
                        err_kick = 1'b1;
                    end else if (ctrl_hit) begin
                        st_d    = ST_ALU_WORK;
                        start_d = 1'b1;
                    end else if (hwrite) begin
                        st_d    = ST_ACCESS;
                        dir_w_d = 1'b1;
                        we_d    = 1'b1;
                    end else if ((st_q == ST_ACCESS) && !dir_w_q && xf_seq) begin
                        st_d = ST_ACCESS;
                        re_d = 1'b1;
                    end else begin
                        st_d      = ST_RD_WAIT;
                        dir_w_d   = 1'b0;
                        wait_load = 1'b1;
                    end
                end else if (xf_busy && (st_q != ST_IDLE)) begin
                    st_d = dir_w_q ? ST_WR_WAIT : ST_ACCESS;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_RD_WAIT: begin
                if (wait_last) begin
                    st_d = ST_ACCESS;
                    re_d = 1'b1;
                end
            end
            ST_ERROR: begin
                if (ph_second) begin
                    st_d = ST_IDLE;
                end
            end
            ST_ALU_WORK: begin
                done_pend_d = done_pend_q || eng_done;
                if (ph_first) begin
                    st_d = ST_ALU_WORK;
                end else if (xf_act) begin
                    rty_kick = 1'b1;
                end else if (done_pend_q || eng_done) begin
                    st_d        = ST_IDLE;
                    done_pend_d = 1'b0;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, direction, pending-done and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            dir_w_q     <= 1'b0;
            done_pend_q <= 1'b0;
            re_q        <= 1'b0;
            we_q        <= 1'b0;
            start_q     <= 1'b0;
        end else begin
            st_q        <= st_d;
            dir_w_q     <= dir_w_d;
            done_pend_q <= done_pend_d;
            re_q        <= re_d;
            we_q        <= we_d;
            start_q     <= start_d;
        end
    end

    // Ready and response follow the registered state only.
    always_comb begin
        hreadyout = !((st_q == ST_RD_WAIT)
                   || ((st_q == ST_ERROR) && ph_first)
                   || ((st_q == ST_ALU_WORK) && ph_first));
        if (st_q == ST_ERROR) begin
            hresp = RSP_ERROR;
        end else if ((st_q == ST_ALU_WORK) && (ph_first || ph_second)) begin
            hresp = RSP_RETRY;
        end else begin
            hresp = RSP_OKAY;
        end
    end

    assign mem_re    = re_q;
    assign mem_we    = we_q;
    assign eng_start = start_q;

    // R8: ERROR starts with a wait cycle and ends with a ready cycle.
    assert_err_two_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp == RSP_ERROR && !hreadyout) |=> (hresp == RSP_ERROR && hreadyout));

    // R11: RETRY has the same two-cycle shape.
    assert_retry_two_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp == RSP_RETRY && !hreadyout) |=> (hresp == RSP_RETRY && hreadyout));

    // R11: no memory strobe while the engine state persists.
    assert_no_mem_in_work_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ALU_WORK) |=> (!mem_we && !mem_re));

    // R10: the start strobe lasts one cycle.
    assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R3: strobes never overlap.
    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_re, mem_we, eng_start}));

    // R4: a fresh valid read from Idle opens with a wait cycle.
    assert_read_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && xf_nonseq && !hwrite && addr_ok && !ctrl_hit)
        |=> (!hreadyout && hresp == RSP_OKAY));

    // R2: in Idle with no active beat the slave stays quiet.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !xf_act)
        |=> (hreadyout && hresp == RSP_OKAY && !mem_we && !mem_re && !eng_start));

endmodule

// File: tb/ahb_slave_ctrl_fsm_tb.sv
`timescale 1ns/1ps
// Bench: behavioural model compared against the block on every clock.
module ahb_slave_ctrl_fsm_tb_top;

    localparam int LAT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsel = 1'b0;
    logic [1:0] htrans = 2'b00;
    logic       hwrite = 1'b0;
    logic       addr_ok = 1'b1;
    logic       ctrl_hit = 1'b0;
    logic       eng_done = 1'b0;
    logic       hreadyout;
    logic [1:0] hresp;
    logic       mem_re, mem_we, eng_start;
    logic       hready_w;

    int compared = 0;
    int mismatched = 0;
    bit chk_on = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    assign hready_w = hreadyout;

    ahb_slave_ctrl_fsm #(.RD_LAT(LAT)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsel      (hsel),
        .htrans    (htrans),
        .hwrite    (hwrite),
        .hready    (hready_w),
        .addr_ok   (addr_ok),
        .ctrl_hit  (ctrl_hit),
        .eng_done  (eng_done),
        .hreadyout (hreadyout),
        .hresp     (hresp),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .eng_start (eng_start)
    );

    // Model state: 0 idle, 1 accessible, 2 working, 3 read wait, 4 write pause, 5 error
    int  m_mode, m_left, m_step;
    bit  m_wr, m_donep;
    bit  e_ready, e_re, e_we, e_st;
    logic [1:0] e_resp;

    // Behavioural reference model, advanced on each rising edge.
    always @(posedge clk) begin
        bit act, bsy, bad, n_re, n_we, n_st;
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_step = 0; m_wr = 0; m_donep = 0;
            n_re = 0; n_we = 0; n_st = 0;
        end else begin
            act  = hsel && e_ready && (htrans == 2'b10 || htrans == 2'b11);
            bsy  = hsel && e_ready && (htrans == 2'b01);
            n_re = 0; n_we = 0; n_st = 0;
            if (m_mode == 0 || m_mode == 1 || m_mode == 4) begin
                if (act) begin
                    bad = !addr_ok || (m_mode == 0 && htrans == 2'b11) ||
                          (ctrl_hit && !(m_mode == 0 && htrans == 2'b10 && hwrite));
                    if (bad) begin m_mode = 5; m_step = 1; end
                    else if (ctrl_hit) begin m_mode = 2; m_step = 0; m_donep = 0; n_st = 1; end
                    else if (hwrite) begin m_mode = 1; m_wr = 1; n_we = 1; end
                    else if (m_mode == 1 && !m_wr && htrans == 2'b11) n_re = 1;
                    else begin m_mode = 3; m_left = LAT; m_wr = 0; end
                end else if (bsy && m_mode != 0) m_mode = m_wr ? 4 : 1;
                else m_mode = 0;
            end else if (m_mode == 3) begin
                m_left = m_left - 1;
                if (m_left == 0) begin m_mode = 1; n_re = 1; end
            end else if (m_mode == 5) begin
                if (m_step == 1) m_step = 2;
                else begin m_mode = 0; m_step = 0; end
            end else begin
                if (eng_done) m_donep = 1;
                if (m_step == 1) m_step = 2;
                else if (act) m_step = 1;
                else begin
                    m_step = 0;
                    if (m_donep) begin m_mode = 0; m_donep = 0; end
                end
            end
        end
        e_re = n_re; e_we = n_we; e_st = n_st;
        e_ready = !(m_mode == 3 || (m_mode == 5 && m_step == 1) || (m_mode == 2 && m_step == 1));
        e_resp  = (m_mode == 5) ? 2'b01 : ((m_mode == 2 && m_step != 0) ? 2'b10 : 2'b00);
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (chk_on) begin
            compared++;
            if (hreadyout !== e_ready || hresp !== e_resp || mem_re !== e_re ||
                mem_we !== e_we || eng_start !== e_st) begin
                mismatched++;
                $display("FAIL %s t=%0t actual rdy=%b rsp=%b re=%b we=%b st=%b expected rdy=%b rsp=%b re=%b we=%b st=%b",
                         cur_req, $time, hreadyout, hresp, mem_re, mem_we, eng_start,
                         e_ready, e_resp, e_re, e_we, e_st);
            end
        end
    end

    // Present one address phase and hold it until the slave is ready.
    task automatic put(input logic s, input logic [1:0] t, input logic w,
                       input logic ok, input logic c);
        bit taken;
        hsel = s; htrans = t; hwrite = w; addr_ok = ok; ctrl_hit = c;
        do begin
            taken = hready_w;
            @(negedge clk);
        end while (!taken);
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        compared++;
        if (hreadyout !== 1'b1 || hresp !== 2'b00 || mem_re || mem_we || eng_start) begin
            mismatched++;
            $display("FAIL R1 actual rdy=%b rsp=%b re=%b we=%b st=%b expected rdy=1 rsp=00 strobes 0",
                     hreadyout, hresp, mem_re, mem_we, eng_start);
        end
        chk_on = 1'b1;

        cur_req = "R2";
        idle_n(2);
        put(1, 2'b01, 1, 1, 0);
        put(0, 2'b10, 1, 1, 0);
        put(1, 2'b00, 0, 1, 0);
        idle_n(2);

        cur_req = "R3";
        put(1, 2'b10, 1, 1, 0);
        put(1, 2'b11, 1, 1, 0);
        put(1, 2'b11, 1, 1, 0);
        idle_n(2);

        cur_req = "R6";
        put(1, 2'b10, 1, 1, 0);
        put(1, 2'b01, 1, 1, 0);
        put(1, 2'b01, 1, 1, 0);
        put(1, 2'b11, 1, 1, 0);
        idle_n(2);

        cur_req = "R4";
        put(1, 2'b10, 0, 1, 0);
        cur_req = "R5";
        put(1, 2'b11, 0, 1, 0);
        put(1, 2'b11, 0, 1, 0);
        put(1, 2'b01, 0, 1, 0);
        put(1, 2'b11, 0, 1, 0);
        idle_n(4);

        cur_req = "R7";
        put(1, 2'b10, 1, 1, 0);
        put(1, 2'b10, 0, 1, 0);
        put(1, 2'b10, 0, 1, 0);
        put(1, 2'b11, 0, 1, 0);
        idle_n(4);

        cur_req = "R8";
        put(1, 2'b10, 1, 0, 0);
        put(1, 2'b10, 1, 1, 0);
        idle_n(3);
        put(1, 2'b10, 0, 1, 0);
        put(1, 2'b11, 0, 0, 0);
        idle_n(3);

        cur_req = "R9";
        put(1, 2'b11, 1, 1, 0);
        idle_n(3);

        cur_req = "R13";
        put(1, 2'b10, 1, 1, 0);
        put(1, 2'b10, 1, 1, 1);
        idle_n(3);
        put(1, 2'b10, 0, 1, 1);
        idle_n(3);

        cur_req = "R10";
        put(1, 2'b10, 1, 1, 1);
        idle_n(2);
        cur_req = "R11";
        put(1, 2'b10, 0, 1, 0);
        idle_n(3);
        put(1, 2'b10, 1, 1, 0);
        put(1, 2'b11, 1, 1, 0);
        idle_n(3);
        put(1, 2'b10, 1, 1, 1);
        idle_n(3);

        cur_req = "R12";
        eng_done = 1'b1;
        put(1, 2'b10, 1, 1, 0);
        eng_done = 1'b0;
        idle_n(4);
        put(1, 2'b10, 1, 1, 0);
        idle_n(2);
        put(1, 2'b10, 1, 1, 1);
        eng_done = 1'b1;
        idle_n(1);
        eng_done = 1'b0;
        idle_n(2);
        put(1, 2'b10, 0, 1, 0);
        idle_n(4);

        chk_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule